// File: doc/BRIEF.md
# Timing Loop Mode Controller

This block decides the operating mode of a digital timing loop and picks the frequency word that drives the loop's synthesizer. It has three modes: free-run, locked and holdover. It moves between them without any software action. In free-run it drives a nominal word plus a calibration offset. It declares lock after a configurable run of consecutive in-tolerance phase samples on a valid reference. While locked, it passes the loop's own frequency word through to the synthesizer.

While locked, the controller also keeps an exponential moving average of the loop frequency word. When the reference fails, it drives that average, so the output frequency does not jump. While in holdover it asks the reference selector for another valid input and relocks once that input is acquired.

A configuration bit selects revertive switching. In revertive mode, when the loop is locked to a backup reference and the top-priority reference becomes valid again, the controller asks the selector to switch back.

Top module: `loop_mode_ctrl`

## Requirements
- R1: After reset, mode_o is free-run (encoding 0; locked is 1, holdover is 2), switch_req_o is 0 and no holdover average is held.
- R2: In free-run, freq_o equals NOMINAL plus cal_offset_i, where cal_offset_i is a two's-complement value and the sum wraps modulo 2^W.
- R3: Lock is declared when lock_len_i consecutive strobes arrive with phase_ok_i high and ref_valid_i high. A strobe with phase_ok_i low, or a cycle with ref_valid_i low, restarts the count. A length of 0 acts as 1. Mode becomes locked at the clock edge that samples the final qualifying strobe.
- R4: In locked, freq_o equals loop_freq_i.
- R5: The holdover average is updated only on a strobe while locked with ref_valid_i high. The first such update after reset loads the sample. Each later update adds (sample − average) >>> avg_shift_i, using arithmetic shift.
- R6: When the loop is locked and ref_valid_i is low, the next edge enters holdover if an average exists and free-run otherwise.
- R7: In holdover, freq_o equals the stored average and does not follow loop_freq_i.
- R8: In holdover, switch_req_o equals alt_valid_i. A reference that then qualifies per R3 returns the mode to locked, and the stored average is kept.
- R9: In locked, switch_req_o is 1 only when revertive_i, primary_valid_i and not on_primary_i are all true. With revertive_i low, switch_req_o stays 0.
- R10: With ref_valid_i held low, holdover persists indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_valid_i | input | 1 | Selected reference is valid |
| sample_stb_i | input | 1 | Phase/frequency sample strobe |
| phase_ok_i | input | 1 | Phase sample within tolerance |
| loop_freq_i | input | W | Loop frequency word |
| cal_offset_i | input | W | Free-run calibration offset (two's complement) |
| avg_shift_i | input | KW | Averaging shift K |
| lock_len_i | input | NW | Consecutive good samples needed for lock |
| alt_valid_i | input | 1 | Another valid reference exists |
| revertive_i | input | 1 | Revertive switching enabled |
| on_primary_i | input | 1 | Selected reference is the top-priority one |
| primary_valid_i | input | 1 | Top-priority reference is valid |
| mode_o | output | 2 | Current mode |
| freq_o | output | W | Frequency word to synthesizer |
| switch_req_o | output | 1 | Request reference change |

## Verification
The bench breaks a run of good phase samples with one bad sample. A design that counted total samples instead of consecutive ones would then lock too early. It feeds a varied sample sequence and compares the holdover word against the arithmetic-shift average; a logical shift or a missing seed gives the wrong word once samples fall below the average. It drops the reference before any average exists, where a careless design would enter holdover with a stale zero. It also checks that strobes outside the locked mode leave the average untouched, and that lock length 0 still locks on a single sample.

// File: rtl/loop_mode_pkg.sv
package loop_mode_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_LOCK = 2'd1,
    MODE_HOLD = 2'd2
  } mode_e;
endpackage

// File: rtl/lock_detect.sv
module lock_detect #(
  parameter int NW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          ref_valid_i,
  input  logic          stb_i,
  input  logic          ok_i,
  input  logic [NW-1:0] len_i,
  output logic          hit_o
);
  logic [NW-1:0] cnt_q;
  logic [NW:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + (NW+1)'(1);
  // len 0 behaves as 1: cnt_nx >= 1 always
  assign hit_o  = ref_valid_i & stb_i & ok_i & (cnt_nx >= {1'b0, len_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clear_i || !ref_valid_i)  cnt_q <= '0;
    else if (stb_i) begin
      if (!ok_i || hit_o)              cnt_q <= '0;
      else                             cnt_q <= cnt_nx[NW-1:0];
    end
  end
endmodule

// File: rtl/holdover_avg.sv
module holdover_avg #(
  parameter int W  = 24,
  parameter int KW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic [W-1:0]  sample_i,
  input  logic [KW-1:0] shift_i,
  output logic [W-1:0]  avg_o,
  output logic          valid_o
);
  logic [W-1:0]        avg_q;
  logic                valid_q;
  logic signed [W:0]   diff;
  logic signed [W:0]   step;
  logic signed [W:0]   sum;

  assign diff = $signed({1'b0, sample_i}) - $signed({1'b0, avg_q});
  assign step = diff >>> shift_i;
  assign sum  = $signed({1'b0, avg_q}) + step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avg_q   <= '0;
      valid_q <= 1'b0;
    end else if (upd_i) begin
      avg_q   <= valid_q ? sum[W-1:0] : sample_i;  // first sample seeds
      valid_q <= 1'b1;
    end
  end

  assign avg_o   = avg_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
  import loop_mode_pkg::*;
#(
  parameter int          W       = 24,
  parameter logic [W-1:0] NOMINAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ref_valid_i,
  input  logic         lock_hit_i,
  input  logic         avg_valid_i,
  input  logic [W-1:0] avg_i,
  input  logic [W-1:0] loop_freq_i,
  input  logic [W-1:0] cal_offset_i,
  input  logic         alt_valid_i,
  input  logic         revertive_i,
  input  logic         on_primary_i,
  input  logic         primary_valid_i,
  output mode_e        mode_o,
  output logic [W-1:0] freq_o,
  output logic         switch_req_o
);
  mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_LOCK: if (!ref_valid_i) mode_d = avg_valid_i ? MODE_HOLD : MODE_FREE;
      MODE_FREE,
      MODE_HOLD: if (lock_hit_i)   mode_d = MODE_LOCK;
      default:                     mode_d = MODE_FREE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_FREE;
    else         mode_q <= mode_d;
  end

  always_comb begin
    freq_o       = NOMINAL + cal_offset_i;
    switch_req_o = 1'b0;
    case (mode_q)
      MODE_LOCK: begin
        freq_o       = loop_freq_i;
        switch_req_o = revertive_i & primary_valid_i & ~on_primary_i;
      end
      MODE_HOLD: begin
        freq_o       = avg_i;
        switch_req_o = alt_valid_i;
      end
      default: ;
    endcase
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/loop_mode_ctrl.sv
module loop_mode_ctrl
  import loop_mode_pkg::*;
#(
  parameter int           W       = 24,
  parameter int           KW      = 4,
  parameter int           NW      = 8,
  parameter logic [W-1:0] NOMINAL = {1'b1, {(W-1){1'b0}}}
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ref_valid_i,
  input  logic          sample_stb_i,
  input  logic          phase_ok_i,
  input  logic [W-1:0]  loop_freq_i,
  input  logic [W-1:0]  cal_offset_i,
  input  logic [KW-1:0] avg_shift_i,
  input  logic [NW-1:0] lock_len_i,
  input  logic          alt_valid_i,
  input  logic          revertive_i,
  input  logic          on_primary_i,
  input  logic          primary_valid_i,
  output logic [1:0]    mode_o,
  output logic [W-1:0]  freq_o,
  output logic          switch_req_o
);
  mode_e        mode;
  logic         lock_hit;
  logic         avg_valid;
  logic         avg_upd;
  logic [W-1:0] avg;

  assign avg_upd = (mode == MODE_LOCK) & sample_stb_i & ref_valid_i;

  lock_detect #(.NW(NW)) u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (mode == MODE_LOCK),
    .ref_valid_i (ref_valid_i),
    .stb_i       (sample_stb_i),
    .ok_i        (phase_ok_i),
    .len_i       (lock_len_i),
    .hit_o       (lock_hit)
  );

  holdover_avg #(.W(W), .KW(KW)) u_avg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (avg_upd),
    .sample_i (loop_freq_i),
    .shift_i  (avg_shift_i),
    .avg_o    (avg),
    .valid_o  (avg_valid)
  );

  mode_fsm #(.W(W), .NOMINAL(NOMINAL)) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .ref_valid_i     (ref_valid_i),
    .lock_hit_i      (lock_hit),
    .avg_valid_i     (avg_valid),
    .avg_i           (avg),
    .loop_freq_i     (loop_freq_i),
    .cal_offset_i    (cal_offset_i),
    .alt_valid_i     (alt_valid_i),
    .revertive_i     (revertive_i),
    .on_primary_i    (on_primary_i),
    .primary_valid_i (primary_valid_i),
    .mode_o          (mode),
    .freq_o          (freq_o),
    .switch_req_o    (switch_req_o)
  );

  assign mode_o = mode;
endmodule

// File: rtl/loop_mode_ctrl_chk.sv
module loop_mode_ctrl_chk #(
  parameter int W = 24
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         ref_valid_i,
  input logic         sample_stb_i,
  input logic         phase_ok_i,
  input logic         alt_valid_i,
  input logic         revertive_i,
  input logic [1:0]   mode_o,
  input logic [W-1:0] freq_o,
  input logic         switch_req_o
);
  localparam logic [1:0] LK = 2'd1;
  localparam logic [1:0] HO = 2'd2;

  // R1
  mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3);

  // R3
  lock_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_o == LK) |-> $past(ref_valid_i && sample_stb_i && phase_ok_i));

  // R6
  ref_loss_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == LK && !ref_valid_i) |=> mode_o != LK);

  // R6
  hold_from_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_o == HO) |-> $past(mode_o == LK));

  // R7
  hold_freq_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == HO && $past(mode_o == HO)) |-> $stable(freq_o));

  // R8
  hold_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == HO && !alt_valid_i) |-> !switch_req_o);

  // R9
  nonrevert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == LK && !revertive_i) |-> !switch_req_o);
endmodule

bind loop_mode_ctrl loop_mode_ctrl_chk #(.W(W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ref_valid_i  (ref_valid_i),
  .sample_stb_i (sample_stb_i),
  .phase_ok_i   (phase_ok_i),
  .alt_valid_i  (alt_valid_i),
  .revertive_i  (revertive_i),
  .mode_o       (mode_o),
  .freq_o       (freq_o),
  .switch_req_o (switch_req_o)
);

// File: tb/loop_mode_ctrl_test.sv
`timescale 1ns/1ps
module loop_mode_ctrl_test;
  localparam int          W   = 24;
  localparam int          KW  = 4;
  localparam int          NW  = 8;
  localparam logic [W-1:0] NOM = 24'h800000;
  localparam logic [1:0]  M_FREE = 2'd0, M_LOCK = 2'd1, M_HOLD = 2'd2;
  localparam int          NS  = 8;
  localparam logic [W-1:0] SAMPLES [NS] = '{
    24'h800100, 24'h800140, 24'h7FFF00, 24'h800000,
    24'h8003A5, 24'h7FFFF1, 24'h800007, 24'h7FF800
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_valid = 1'b0, stb = 1'b0, ok = 1'b0;
  logic [W-1:0]  loop_freq = '0, cal = '0;
  logic [KW-1:0] shift = 4'd2;
  logic [NW-1:0] len = 8'd3;
  logic          alt_valid = 1'b0, revert = 1'b0, on_pri = 1'b1, pri_valid = 1'b0;
  logic [1:0]    mode;
  logic [W-1:0]  freq;
  logic          sreq;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model_avg;

  always #5 clk = ~clk;

  loop_mode_ctrl #(.W(W), .KW(KW), .NW(NW), .NOMINAL(NOM)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_valid_i(ref_valid), .sample_stb_i(stb),
    .phase_ok_i(ok), .loop_freq_i(loop_freq), .cal_offset_i(cal),
    .avg_shift_i(shift), .lock_len_i(len), .alt_valid_i(alt_valid),
    .revertive_i(revert), .on_primary_i(on_pri), .primary_valid_i(pri_valid),
    .mode_o(mode), .freq_o(freq), .switch_req_o(sreq)
  );

  function automatic logic [W-1:0] ema(input logic [W-1:0] a, input logic [W-1:0] s,
                                       input int k);
    longint d;
    d = longint'(s) - longint'(a);
    return W'(longint'(a) + (d >>> k));
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok_c, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok_c) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic good);
    stb = 1'b1; ok = good;
    step();
    stb = 1'b0; ok = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cal = 24'd5;
    repeat (2) step();
    // R1 reset state
    chk(mode == M_FREE, "R1 mode", mode, M_FREE);
    chk(sreq == 1'b0, "R1 switch_req", sreq, 0);
    rst_n = 1'b1;
    step();
    // R2 free-run word, positive and negative offset
    chk(freq == NOM + 24'd5, "R2 free +5", freq, NOM + 24'd5);
    cal = -24'sd3;
    #1 chk(freq == NOM - 24'd3, "R2 free -3", freq, NOM - 24'd3);

    // R3 lock needs consecutive good samples
    ref_valid = 1'b1;
    strobe(1'b1); strobe(1'b1); strobe(1'b0);
    strobe(1'b1); strobe(1'b1);
    chk(mode == M_FREE, "R3 not yet locked", mode, M_FREE);
    strobe(1'b1);
    chk(mode == M_LOCK, "R3 locked", mode, M_LOCK);

    // R4 locked passes loop word
    loop_freq = 24'h812345;
    #1 chk(freq == 24'h812345, "R4 locked freq", freq, 24'h812345);

    // R5 averaging, vector table
    for (int i = 0; i < NS; i++) begin
      loop_freq = SAMPLES[i];
      model_avg = (i == 0) ? SAMPLES[i] : ema(model_avg, SAMPLES[i], int'(shift));
      strobe(1'b1);
    end
    shift = 4'd1;
    loop_freq = 24'h7F0000;
    model_avg = ema(model_avg, 24'h7F0000, 1);
    strobe(1'b1);
    shift = 4'd2;

    // R6 loss of reference -> holdover
    ref_valid = 1'b0;
    step();
    chk(mode == M_HOLD, "R6 holdover", mode, M_HOLD);
    chk(freq == model_avg, "R5 average", freq, model_avg);
    // R7 holdover ignores loop word and strobes
    loop_freq = 24'h123456;
    strobe(1'b1);
    chk(freq == model_avg, "R7 hold freq", freq, model_avg);

    // R8 switch request follows alt valid
    #1 chk(sreq == 1'b0, "R8 no alt", sreq, 0);
    alt_valid = 1'b1;
    #1 chk(sreq == 1'b1, "R8 alt", sreq, 1);
    alt_valid = 1'b0;
    // R10 stays in holdover
    repeat (20) step();
    chk(mode == M_HOLD, "R10 persist", mode, M_HOLD);
    chk(freq == model_avg, "R10 hold freq", freq, model_avg);

    // R8 relock, average retained
    ref_valid = 1'b1;
    strobe(1'b1); strobe(1'b1);
    chk(mode == M_HOLD, "R8 relock pending", mode, M_HOLD);
    strobe(1'b1);
    chk(mode == M_LOCK, "R8 relocked", mode, M_LOCK);
    loop_freq = 24'h800800;
    model_avg = ema(model_avg, 24'h800800, 2);
    strobe(1'b1);

    // R9 revertive request
    on_pri = 1'b0; pri_valid = 1'b1; revert = 1'b1;
    #1 chk(sreq == 1'b1, "R9 revert req", sreq, 1);
    revert = 1'b0;
    #1 chk(sreq == 1'b0, "R9 nonrevert", sreq, 0);
    on_pri = 1'b1; revert = 1'b1;
    #1 chk(sreq == 1'b0, "R9 on primary", sreq, 0);
    revert = 1'b0; pri_valid = 1'b0;

    ref_valid = 1'b0;
    step();
    chk(freq == model_avg, "R5 avg after relock", freq, model_avg);

    // R6 fallback to free-run with no average; R3 len 0
    rst_n = 1'b0; step(); rst_n = 1'b1; step();
    cal = 24'd0; len = 8'd0; ref_valid = 1'b1;
    strobe(1'b1);
    chk(mode == M_LOCK, "R3 len0 lock", mode, M_LOCK);
    ref_valid = 1'b0;
    step();
    chk(mode == M_FREE, "R6 no avg free", mode, M_FREE);
    chk(freq == NOM, "R2 free after fallback", freq, NOM);

    // R3 ref invalid breaks count
    len = 8'd2; ref_valid = 1'b1;
    strobe(1'b1);
    ref_valid = 1'b0; step(); ref_valid = 1'b1;
    strobe(1'b1);
    chk(mode == M_FREE, "R3 ref gap restart", mode, M_FREE);
    strobe(1'b1);
    chk(mode == M_LOCK, "R3 lock after gap", mode, M_LOCK);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule